// File: doc/BRIEF.md
# Buck Regulator Soft-Start and Fault Sequencer

This block is the digital sequencer of a synchronous buck regulator. It runs on the system clock and advances its timers only on cycles where the oscillator tick input is high. At the default settings this tick comes at 300 kHz. The inputs are four comparator flags that have already been synchronised:

- supply above its power-on threshold;
- compensation node above its enable threshold;
- over-current trip on the low-side switch;
- feedback under-voltage, meaning feedback is below half the reference.

Once both the supply and enable flags are high, the sequencer waits through a fixed power-up delay. It then raises a digital reference code as a staircase, one step at a time, until the code reaches its final value, and then it regulates.

The first over-current event restarts the staircase from code zero. A second over-current event latches the regulator off. An under-voltage event during regulation also latches it off. Only dropping the supply-ready flag clears the latched state, and that drop also clears the over-current count. The outputs are the reference DAC code, a PWM enable, one off control for each gate, and a state code.

Top module: `buck_softstart_seq`

## Requirements
- R1: The block leaves the off state (state code 0) only when `supply_ok` and `comp_en` are both high. The step into the delay state (code 1) happens on the next clock edge.
- R2: The delay state lasts `DELAY_TICKS` oscillator ticks. The ramp state (code 2) is entered with reference code 0 on the edge of the last delay tick.
- R3: In the ramp state the reference code rises by one every `STEP_TICKS` ticks, so after t ticks of ramp it equals floor(t / `STEP_TICKS`). `pwm_en` is 1 and both gate-off outputs are 0.
- R4: On the tick that would complete step `STEPS`, the block enters the run state (code 3) with reference code `STEPS`. It holds that code while it stays in run.
- R5: The first over-current trip seen in ramp or run sends the block to the ramp state with reference code 0 at the next edge. It does not repeat the power-up delay.
- R6: The second counted over-current trip sends the block to the fault state (code 4). The fault state ignores `comp_en`, `ocp_trip` and `uv_trip`.
- R7: An under-voltage trip in the run state enters the fault state at the next edge. `uv_trip` is ignored in the delay and ramp states.
- R8: `comp_en` low in the delay, ramp or run state returns the block to the off state at the next edge.
- R9: `supply_ok` low returns the block to the off state from any state, including fault, and clears the over-current count. It is the only way out of the fault state.
- R10: The over-current count survives a `comp_en` disable and a completed soft-start.
- R11: Outside the ramp and run states, `pwm_en` is 0, `hs_off` and `ls_off` are 1, the reference code is 0, and `ocp_trip` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| osc_tick | input | 1 | One-clock pulse per oscillator period |
| supply_ok | input | 1 | Supply above power-on threshold |
| comp_en | input | 1 | Compensation node above enable threshold |
| ocp_trip | input | 1 | Low-side over-current comparator |
| uv_trip | input | 1 | Feedback under-voltage comparator |
| ref_code | output | CODE_W (7) | Reference DAC code, 0 to STEPS |
| pwm_en | output | 1 | PWM modulator enable |
| hs_off | output | 1 | Force high-side gate off |
| ls_off | output | 1 | Force low-side gate low |
| state_o | output | 3 | 0 off, 1 delay, 2 ramp, 3 run, 4 fault |

## Verification
The hardest situation to reach from the ports is a latched fault caused by an over-current count that has outlived other events. Two such paths exist. In one, the first trip is followed by a `comp_en` disable in mid-ramp and a full restart. In the other, the first trip is followed by a second complete staircase. The bench reaches both by running complete start-ups on a small configuration and checking every ramp tick against floor(t / `STEP_TICKS`). It places single-clock over-current pulses at chosen ticks and checks that only a `supply_ok` drop releases the fault.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  typedef enum logic [2:0] {
    SQ_OFF   = 3'd0,
    SQ_DELAY = 3'd1,
    SQ_RAMP  = 3'd2,
    SQ_RUN   = 3'd3,
    SQ_FAULT = 3'd4
  } sq_state_e;
endpackage

// File: rtl/ssq_interval.sv
// Tick-driven interval counter: done pulses on the LIMIT-th advance.
module ssq_interval #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic done
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign done = adv && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (done) cnt_d = '0;
    else if (adv)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2/R3: counter never runs past its interval
  a_r3_interval_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/ssq_ramp.sv
// Reference staircase register.
module ssq_ramp #(
  parameter int STEPS = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         inc,
  output logic [$clog2(STEPS+1)-1:0]   code,
  output logic                         top
);
  localparam int CW = $clog2(STEPS + 1);

  logic [CW-1:0] code_q, code_d;

  assign code = code_q;
  assign top  = inc && (code_q == CW'(STEPS - 1));

  always_comb begin
    code_d = code_q;
    if (clr)      code_d = '0;
    else if (inc) code_d = code_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  a_r3_ramp_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> code_q == $past(code_q) + 1'b1);
  a_r4_ramp_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    code_q <= CW'(STEPS));
endmodule

// File: rtl/ssq_ocp_count.sv
// Over-current event counter, cleared only by power-on reset.
module ssq_ocp_count #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_clr,
  input  logic event_i,
  output logic final_o
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign final_o = event_i && (cnt_q >= LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (por_clr)                           cnt_d = '0;
    else if (event_i && cnt_q < W'(LIMIT)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r10_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_clr && !event_i) |=> $stable(cnt_q));
endmodule

// File: rtl/buck_softstart_seq.sv
module buck_softstart_seq
  import ssq_pkg::*;
#(
  parameter int DELAY_TICKS = 480,
  parameter int STEP_TICKS  = 8,
  parameter int STEPS       = 64,
  parameter int OCP_LIMIT   = 2,
  localparam int CODE_W     = $clog2(STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              supply_ok,
  input  logic              comp_en,
  input  logic              ocp_trip,
  input  logic              uv_trip,
  output logic [CODE_W-1:0] ref_code,
  output logic              pwm_en,
  output logic              hs_off,
  output logic              ls_off,
  output logic [2:0]        state_o
);
  sq_state_e state_q, state_d;

  logic in_active, uv_hit, ocp_ev, ocp_final;
  logic dly_clr, dly_adv, dly_done;
  logic stp_clr, stp_adv, stp_done;
  logic rmp_clr, rmp_inc, rmp_top;
  logic [CODE_W-1:0] code;

  assign in_active = (state_q == SQ_RAMP) || (state_q == SQ_RUN);
  assign uv_hit    = (state_q == SQ_RUN) && uv_trip;
  assign ocp_ev    = supply_ok && comp_en && in_active && ocp_trip && !uv_hit;

  // timers and staircase control
  assign dly_clr = (state_q != SQ_DELAY);
  assign dly_adv = (state_q == SQ_DELAY) && osc_tick;
  assign stp_clr = (state_q != SQ_RAMP) || ocp_ev;
  assign stp_adv = (state_q == SQ_RAMP) && osc_tick;
  assign rmp_clr = !in_active || ocp_ev;
  assign rmp_inc = stp_done && !ocp_ev;

  ssq_interval #(.LIMIT(DELAY_TICKS)) u_delay (
    .clk(clk), .rst_n(rst_n), .clr(dly_clr), .adv(dly_adv), .done(dly_done));

  ssq_interval #(.LIMIT(STEP_TICKS)) u_step (
    .clk(clk), .rst_n(rst_n), .clr(stp_clr), .adv(stp_adv), .done(stp_done));

  ssq_ramp #(.STEPS(STEPS)) u_ramp (
    .clk(clk), .rst_n(rst_n), .clr(rmp_clr), .inc(rmp_inc),
    .code(code), .top(rmp_top));

  ssq_ocp_count #(.LIMIT(OCP_LIMIT)) u_ocp (
    .clk(clk), .rst_n(rst_n), .por_clr(!supply_ok), .event_i(ocp_ev),
    .final_o(ocp_final));

  always_comb begin
    state_d = state_q;
    if (!supply_ok) begin
      state_d = SQ_OFF;
    end else begin
      unique case (state_q)
        SQ_OFF:   if (comp_en) state_d = SQ_DELAY;
        SQ_DELAY: begin
          if (!comp_en)      state_d = SQ_OFF;
          else if (dly_done) state_d = SQ_RAMP;
        end
        SQ_RAMP: begin
          if (!comp_en)     state_d = SQ_OFF;
          else if (ocp_ev)  state_d = ocp_final ? SQ_FAULT : SQ_RAMP;
          else if (rmp_top) state_d = SQ_RUN;
        end
        SQ_RUN: begin
          if (!comp_en)    state_d = SQ_OFF;
          else if (uv_hit) state_d = SQ_FAULT;
          else if (ocp_ev) state_d = ocp_final ? SQ_FAULT : SQ_RAMP;
        end
        SQ_FAULT: state_d = SQ_FAULT;
        default:  state_d = SQ_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_OFF;
    else        state_q <= state_d;
  end

  assign pwm_en   = in_active;
  assign hs_off   = !in_active;
  assign ls_off   = !in_active;
  assign ref_code = in_active ? code : '0;
  assign state_o  = state_q;

  a_r9_supply_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> state_q == SQ_OFF);
  a_r6_fault_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_FAULT && supply_ok) |=> state_q == SQ_FAULT);
  a_r7_uv_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_RUN && supply_ok && comp_en && uv_trip) |=> state_q == SQ_FAULT);
  a_r7_uv_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_DELAY && supply_ok && comp_en) |=> state_q != SQ_FAULT);
  a_r8_comp_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && !comp_en && state_q != SQ_FAULT) |=> state_q == SQ_OFF);
  a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ocp_ev && !ocp_final) |=> (state_q == SQ_RAMP && code == '0));
  a_r4_run_holds_top: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_RUN) |-> code == CODE_W'(STEPS));
endmodule

// File: tb/tb_buck_softstart_seq.sv
module tb_buck_softstart_seq;
  localparam int DLY = 6;
  localparam int STP = 3;
  localparam int NST = 8;
  localparam int CW  = $clog2(NST + 1);

  logic clk = 1'b0;
  logic rst_n, osc_tick, supply_ok, comp_en, ocp_trip, uv_trip;
  logic [CW-1:0] ref_code;
  logic pwm_en, hs_off, ls_off;
  logic [2:0] state_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  buck_softstart_seq #(.DELAY_TICKS(DLY), .STEP_TICKS(STP), .STEPS(NST)) dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .supply_ok(supply_ok),
    .comp_en(comp_en), .ocp_trip(ocp_trip), .uv_trip(uv_trip),
    .ref_code(ref_code), .pwm_en(pwm_en), .hs_off(hs_off), .ls_off(ls_off),
    .state_o(state_o));

  task automatic step(input logic t);
    osc_tick = t;
    @(posedge clk);
    @(negedge clk);
    osc_tick = 1'b0;
  endtask

  task automatic expect_out(input string tag, input int st, input int code);
    logic act;
    act = (st == 2) || (st == 3);
    n_tests++;
    if (state_o !== 3'(st) || ref_code !== CW'(code) || pwm_en !== act ||
        hs_off !== !act || ls_off !== !act) begin
      n_fail++;
      $display("FAIL %s: state=%0d code=%0d pwm=%b hs=%b ls=%b exp state=%0d code=%0d pwm=%b",
               tag, state_o, ref_code, pwm_en, hs_off, ls_off, st, code, act);
    end
  endtask

  // R1, R2, R3, R4 sweep; optional noise injected on masked inputs
  task automatic start_up(input bit noise);
    supply_ok = 1'b1; comp_en = 1'b1;
    step(1'b0);
    expect_out("R1 enter delay", 1, 0);
    for (int i = 1; i <= DLY; i++) begin
      if (noise && i == 2) begin ocp_trip = 1'b1; uv_trip = 1'b1; end
      step(1'b1);
      ocp_trip = 1'b0; uv_trip = 1'b0;
      if (i < DLY) expect_out(noise && i == 2 ? "R11 R7 delay masks trips" : "R2 delay", 1, 0);
      else         expect_out("R2 delay end", 2, 0);
    end
    for (int j = 1; j <= NST * STP; j++) begin
      if (noise && j == 4) uv_trip = 1'b1;
      step(1'b1);
      uv_trip = 1'b0;
      if (j < NST * STP) expect_out(noise && j == 4 ? "R7 ramp ignores uv" : "R3 ramp", 2, j / STP);
      else               expect_out("R4 reach run", 3, NST);
    end
  endtask

  task automatic ocp_pulse();
    ocp_trip = 1'b1; step(1'b0); ocp_trip = 1'b0;
  endtask

  task automatic supply_cycle();
    supply_ok = 1'b0; step(1'b0);
    expect_out("R9 supply drop", 0, 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; osc_tick = 1'b0; supply_ok = 1'b0; comp_en = 1'b0;
    ocp_trip = 1'b0; uv_trip = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R11 reset", 0, 0);

    // R1: one flag alone does nothing
    supply_ok = 1'b1; comp_en = 1'b0;
    repeat (3) step(1'b1);
    expect_out("R1 comp low", 0, 0);
    supply_ok = 1'b0; comp_en = 1'b1;
    repeat (3) step(1'b1);
    expect_out("R1 supply low", 0, 0);

    // R4 hold, R7 uv in run, R6 fault ignores inputs, R9 exit
    start_up(1'b1);
    repeat (4) step(1'b1);
    expect_out("R4 run hold", 3, NST);
    uv_trip = 1'b1; step(1'b0); uv_trip = 1'b0;
    expect_out("R7 uv fault", 4, 0);
    comp_en = 1'b0; step(1'b1);
    expect_out("R6 fault ignores comp", 4, 0);
    comp_en = 1'b1; ocp_pulse();
    expect_out("R6 fault ignores ocp", 4, 0);
    supply_cycle();

    // R5 restart, then R6 second trip
    start_up(1'b0);
    ocp_pulse();
    expect_out("R5 restart from run", 2, 0);
    for (int j = 1; j <= NST * STP; j++) begin
      step(1'b1);
      if (j < NST * STP) expect_out("R5 R3 second ramp", 2, j / STP);
      else               expect_out("R5 R4 second run", 3, NST);
    end
    ocp_pulse();
    expect_out("R6 second trip", 4, 0);
    supply_cycle();

    // R10: count survives comp disable and a full start
    start_up(1'b0);
    ocp_pulse();
    expect_out("R5 restart", 2, 0);
    repeat (5) step(1'b1);
    expect_out("R3 partial ramp", 2, 5 / STP);
    comp_en = 1'b0; step(1'b0);
    expect_out("R8 comp drop in ramp", 0, 0);
    start_up(1'b0);
    ocp_pulse();
    expect_out("R10 count retained", 4, 0);
    supply_cycle();

    // R9 clears count: one trip after POR only restarts
    start_up(1'b0);
    ocp_pulse();
    expect_out("R9 count cleared", 2, 0);
    repeat (7) step(1'b1);
    ocp_trip = 1'b1; step(1'b1); ocp_trip = 1'b0;
    expect_out("R6 second trip in ramp", 4, 0);
    supply_cycle();

    // R8 comp drop in run and in delay
    start_up(1'b0);
    comp_en = 1'b0; step(1'b0);
    expect_out("R8 comp drop in run", 0, 0);
    comp_en = 1'b1; step(1'b0);
    expect_out("R1 re-enter delay", 1, 0);
    repeat (2) step(1'b1);
    comp_en = 1'b0; step(1'b1);
    expect_out("R8 comp drop in delay", 0, 0);
    ocp_pulse();
    expect_out("R11 off ignores ocp", 0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule